// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Deferred Disable

This block turns bytes written by a processor into asynchronous serial characters on a single output line. It has two stages. A holding register takes the next byte from the write port. A separate shift stage sends the current character bit by bit. Software can therefore queue one byte while another is still on the line.

Each character has these parts, in this order:
- a start bit;
- 5 to 8 data bits, least significant bit first;
- an optional even or odd parity bit;
- one or two stop bits.

Each bit lasts a fixed number of baud ticks. The frame settings are sampled when a character moves into the shift stage.

Clearing the transmit enable stops the block from accepting new writes. It never discards a byte that was already accepted, and it never cuts a character short. When nothing is left to send, the line rests at mark. A separate break input forces the line to space for as long as it is held.

Top module: `ser_tx`

## Requirements
- R1: After reset `txd_o` is 1, `empty_o` is 1, and `rdy_o` equals `tx_en_i`.
- R2: A character is sent as: start bit 0; then `5+bits_sel_i` data bits, least significant bit first (`bits_sel_i` 0..3 selects 5..8 bits); then, if `par_en_i` is 1, a parity bit; then one stop bit of 1, or two when `stop2_i` is 1. The parity bit is the XOR of the data bits sent, inverted when `par_odd_i` is 1. Each bit lasts OVS (default 16) ticks.
- R3: `rdy_o` is 1 exactly when the holding register is empty and `tx_en_i` is 1. `empty_o` is 1 exactly when both the holding register and the shift stage are empty.
- R4: A write (`wr_i` high at a clock edge) is accepted only while `rdy_o` is 1. A write made while the holding register is full, or while transmit is disabled, is dropped and leaves the pending byte unchanged.
- R5: A byte in the holding register moves into the shift stage at the first clock edge at which the shift stage is idle. The start bit begins on the line after that edge. Back-to-back characters are separated by one clock of mark.
- R6: Clearing `tx_en_i` lets the character in progress and the byte in the holding register both be sent in full.
- R7: Whenever the shift stage is idle and `brk_i` is 0, `txd_o` is 1.
- R8: While `brk_i` is 1, `txd_o` is 0.
- R9: The bit on the line changes only at a clock edge where `tick_i` is 1. With `tick_i` held low, a character in progress freezes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; gates new writes only |
| brk_i | input | 1 | Force line to space while high |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to send |
| tick_i | input | 1 | Baud tick, OVS per bit |
| bits_sel_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity select |
| stop2_i | input | 1 | Two stop bits when high |
| txd_o | output | 1 | Serial line |
| rdy_o | output | 1 | Holding register free and enabled |
| empty_o | output | 1 | Holding and shift stages both empty |

## Verification
The flags follow a write at the very next edge. That same edge fills the holding register, so `rdy_o` falls and `empty_o` falls. The load into the shift stage takes one more edge, so the start bit appears two edges after the write strobe. Each bit then holds for OVS edges. The bench therefore samples every bit eight edges into its window, one time unit after the edge, which keeps every sample clear of transitions. For back-to-back characters, the bench first checks the single clock of mark between them and then begins the next window one edge later. The break and tick-stall checks are taken one time unit after the input changes, or after several stalled edges.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } ph_e;
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OVS      = 16,
  parameter int SEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  bits_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IW = $clog2(DATA_W);

  ph_e               ph_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q, last_q;
  logic [DATA_W-1:0] sh_q;
  logic              pen_q, pbit_q, s2_q;
  logic [IW-1:0]     last_d;
  logic              pbit_d;
  logic              bit_end;

  assign last_d  = IW'(MIN_BITS - 1) + IW'(bits_sel_i);
  assign bit_end = tick_i && (cnt_q == CW'(OVS - 1));

  always_comb begin
    pbit_d = par_odd_i;
    for (int i = 0; i < DATA_W; i++)
      if (IW'(i) <= last_d) pbit_d = pbit_d ^ data_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      sh_q   <= '0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      s2_q   <= 1'b0;
    end else if (load_i) begin
      ph_q   <= PH_START;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= last_d;
      sh_q   <= data_i;
      pen_q  <= par_en_i;
      pbit_q <= pbit_d;
      s2_q   <= stop2_i;
    end else if (ph_q != PH_IDLE && tick_i) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (ph_q)
          PH_START: ph_q <= PH_DATA;
          PH_DATA: begin
            sh_q <= sh_q >> 1;
            if (idx_q == last_q) ph_q <= pen_q ? PH_PAR : PH_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          PH_PAR: ph_q <= PH_STOP;
          PH_STOP: begin
            if (s2_q) s2_q <= 1'b0;
            else ph_q <= PH_IDLE;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: line_o = 1'b0;
      PH_DATA:  line_o = sh_q[0];
      PH_PAR:   line_o = pbit_q;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (ph_q != PH_IDLE);
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int OVS      = 16,
  parameter int SEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic [SEL_W-1:0]  bits_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  output logic              txd_o,
  output logic              rdy_o,
  output logic              empty_o
);
  logic              full, busy, line, take, accept;
  logic [DATA_W-1:0] hold_data;

  assign rdy_o   = tx_en_i & ~full;
  assign accept  = wr_i & rdy_o;
  assign take    = full & ~busy;
  assign empty_o = ~full & ~busy;
  assign txd_o   = ~brk_i & line;

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (full),
    .data_o    (hold_data)
  );

  ser_tx_shift #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .OVS(OVS), .SEL_W(SEL_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (take),
    .data_i     (hold_data),
    .bits_sel_i (bits_sel_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .stop2_i    (stop2_i),
    .busy_o     (busy),
    .line_o     (line)
  );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_i,
  input logic              brk_i,
  input logic              wr_i,
  input logic              tick_i,
  input logic              txd_o,
  input logic              rdy_o,
  input logic              empty_o,
  input logic              busy,
  input logic              full,
  input logic              line,
  input logic [DATA_W-1:0] hold_data
);
  p_idle_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !brk_i) |-> txd_o);

  p_break_space_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);

  p_rdy_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (tx_en_i && !full));

  p_full_keeps_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_i) |=> $stable(hold_data));

  p_load_when_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !busy) |=> (busy && !full));

  p_hold_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick_i) |=> (busy && $stable(line)));

  p_no_midchar_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(tick_i));
endmodule

bind ser_tx ser_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .brk_i     (brk_i),
  .wr_i      (wr_i),
  .tick_i    (tick_i),
  .txd_o     (txd_o),
  .rdy_o     (rdy_o),
  .empty_o   (empty_o),
  .busy      (busy),
  .full      (full),
  .line      (line),
  .hold_data (hold_data)
);

// File: tb/ser_tx_test.sv
module ser_tx_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en = 1'b0, brk = 1'b0, wr = 1'b0, tick = 1'b1;
  logic [7:0] wdata = '0;
  logic [1:0] bsel = '0;
  logic pen = 1'b0, podd = 1'b0, s2 = 1'b0;
  logic txd, rdy, empty;
  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  ser_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .brk_i(brk), .wr_i(wr),
    .wr_data_i(wdata), .tick_i(tick), .bits_sel_i(bsel), .par_en_i(pen),
    .par_odd_i(podd), .stop2_i(s2), .txd_o(txd), .rdy_o(rdy), .empty_o(empty)
  );

  // {data, bits_sel, par_en, par_odd, stop2}
  localparam logic [12:0] VEC [6] = '{
    {8'h55, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'hA3, 2'd3, 1'b1, 1'b0, 1'b0},
    {8'hA3, 2'd3, 1'b1, 1'b1, 1'b1},
    {8'h1B, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 2'd1, 1'b0, 1'b0, 1'b1},
    {8'hFF, 2'd2, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  // Called one time unit after the load edge; ends one unit after the final stop edge.
  task automatic frame(input logic [7:0] d, input logic [1:0] c, input logic p_en,
                       input logic p_odd, input logic st2, input string tag);
    int n = 5 + int'(c);
    int total = 1 + n + int'(p_en) + 1 + int'(st2);
    logic par = p_odd;
    for (int i = 0; i < n; i++) par ^= d[i];
    for (int j = 0; j < total; j++) begin
      logic e;
      if (j == 0) e = 1'b0;
      else if (j <= n) e = d[j-1];
      else if (j == n + 1 && p_en) e = par;
      else e = 1'b1;
      repeat (8) @(posedge clk);
      #1 check({7'd0, txd}, {7'd0, e}, $sformatf("R2 %s bit%0d", tag, j));
      repeat (8) @(posedge clk);
    end
    #1;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check({5'd0, txd, empty, rdy}, 8'b110, "R1 reset txd/empty/rdy");
    @(negedge clk); rst_ni = 1'b1;

    // R4: write while disabled is dropped
    @(negedge clk); wr = 1'b1; wdata = 8'h77;
    @(posedge clk); #1 check({7'd0, empty}, 8'd1, "R4 write while disabled dropped");
    @(negedge clk); wr = 1'b0; tx_en = 1'b1;
    #1 check({7'd0, rdy}, 8'd1, "R1 rdy follows enable");
    repeat (40) @(posedge clk);
    #1 check({7'd0, txd}, 8'd1, "R7 idle mark after dropped write");

    // Vector table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      {wdata, bsel, pen, podd, s2} = VEC[i];
      wr = 1'b1;
      @(posedge clk);
      #1 check({6'd0, rdy, empty}, 8'd0, "R3 flags after write");
      @(negedge clk); wr = 1'b0;
      @(posedge clk); #1;
      check({6'd0, rdy, empty}, 8'b10, "R5 holding freed by load");
      frame(VEC[i][12:5], VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));
      check({6'd0, txd, empty}, 8'b11, "R7 mark and empty after frame");
    end

    // Double buffering, full-write drop and deferred disable
    bsel = 2'd3; pen = 1'b1; podd = 1'b0; s2 = 1'b0;
    @(negedge clk); wr = 1'b1; wdata = 8'h4D;
    @(negedge clk); wr = 1'b0;
    @(posedge clk); #1;
    fork
      frame(8'h4D, 2'd3, 1'b1, 1'b0, 1'b0, "R5 first");
      begin
        @(negedge clk); wr = 1'b1; wdata = 8'hB2;
        @(posedge clk); #1 check({7'd0, rdy}, 8'd0, "R3 rdy low when holding full");
        @(negedge clk); wdata = 8'h11;
        @(negedge clk); wr = 1'b0; tx_en = 1'b0;
        #1 check({6'd0, rdy, empty}, 8'd0, "R6 disabled with work pending");
      end
    join
    check({6'd0, txd, empty}, 8'b10, "R5 one clock mark, byte pending");
    @(posedge clk); #1;
    frame(8'hB2, 2'd3, 1'b1, 1'b0, 1'b0, "R6 R4 pending byte kept");
    check({7'd0, empty}, 8'd1, "R6 all sent then empty");
    repeat (200) begin
      @(posedge clk); #1;
      if (txd !== 1'b1 || empty !== 1'b1) break;
    end
    check({6'd0, txd, empty}, 8'b11, "R4 dropped byte never sent");

    // R8: break
    @(negedge clk); brk = 1'b1;
    #1 check({7'd0, txd}, 8'd0, "R8 break forces space");
    repeat (20) @(posedge clk);
    #1 check({7'd0, txd}, 8'd0, "R8 break held");
    @(negedge clk); brk = 1'b0;
    #1 check({7'd0, txd}, 8'd1, "R7 mark after break");

    // R9: tick stall freezes the start bit
    tx_en = 1'b1;
    write_byte(8'hFF);
    @(negedge clk); tick = 1'b0;
    repeat (50) @(posedge clk);
    #1 check({6'd0, txd, empty}, 8'b00, "R9 start bit frozen without ticks");
    @(negedge clk); tick = 1'b1;
    repeat (400) begin
      @(posedge clk); #1;
      if (empty) break;
    end
    check({6'd0, txd, empty}, 8'b11, "R9 frame completes after ticks resume");

    summary();
  end
endmodule